// File: doc/BRIEF.md
# Receive Byte Queue with Line Status

This block sits between the receive shift register of a serial port and the host. Each time the shift register completes a character it presents the byte and a parity-check result for one cycle. The block stores both in a first-in first-out queue and gives the host three live status bits: data ready, overrun and parity error.

The host sees the oldest stored byte at the read port at all times and consumes it with a pop pulse. The parity-error bit always describes that visible byte, not the newest arrival. When a character completes while the queue is full, the character is dropped, the stored bytes are left untouched, and a sticky overrun flag is raised. That flag is cleared when the host reads the status.

Top module: `rx_status_fifo`

## Requirements
- R1: `st_ready_o` is 1 exactly when at least one byte is stored, and 0 when the queue is empty.
- R2: A `wr_valid_i` pulse that arrives while the queue holds DEPTH bytes, with no accepted pop in the same cycle, is dropped. `st_overrun_o` is 1 from the next cycle on.
- R3: A dropped byte does not change the stored bytes. Every byte that was stored before the overrun is later popped with its value, tag and order intact.
- R4: While the queue is not empty, `rd_data_o` shows the oldest stored byte and `st_perr_o` shows that byte's parity tag (1 = parity error). `st_perr_o` is 0 when the queue is empty.
- R5: While `rst_i` is high and on the cycle after it falls, `st_ready_o`, `st_overrun_o` and `st_perr_o` are 0 and `rd_data_o` is 0x00.
- R6: `st_overrun_o` stays 1 until a cycle with `rd_stat_i` high and is 0 on the following cycle. If a new overrun happens in that same cycle, the flag stays 1.
- R7: A write and a pop in the same cycle while the queue is full are both accepted. The count stays DEPTH and no overrun is raised.
- R8: A pop while the queue is empty changes nothing. `rd_data_o` keeps showing the most recently popped byte, or 0x00 if no byte has been popped since reset.
- R9: Bytes come out in arrival order, and the queue holds up to DEPTH (default 32) bytes across any number of pointer wrap-arounds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| wr_valid_i | input | 1 | One-cycle pulse: a character has completed in the shift register |
| wr_data_i | input | 8 | Completed character |
| wr_perr_i | input | 1 | Parity check failed for the completed character |
| rd_pop_i | input | 1 | Host consumes the byte shown on rd_data_o |
| rd_stat_i | input | 1 | Host reads the status; clears the overrun flag |
| rd_data_o | output | 8 | Oldest stored byte, or the last popped byte when the queue is empty |
| st_ready_o | output | 1 | At least one byte is stored |
| st_overrun_o | output | 1 | Sticky flag: a character was dropped because the queue was full |
| st_perr_o | output | 1 | Parity tag of the byte shown on rd_data_o |

## Verification
The bench builds the block with the default DEPTH of 32. The full condition is therefore reached at the capacity the requirements name, and the pointers wrap many times during a long mixed push and pop phase. With this depth, the bench drives the queue to exactly full and then tests every overrun corner at that boundary: a dropped byte, a status read with and without a new overrun in the same cycle, and a simultaneous write and pop when full. It then drains all 32 bytes to confirm that no stored byte was disturbed.

// File: rtl/rxsf_pkg.sv
`timescale 1ns/1ps
package rxsf_pkg;
    localparam int unsigned RX_DATA_W = 8;

    typedef struct packed {
        logic                 perr;
        logic [RX_DATA_W-1:0] data;
    } rx_entry_t;

    typedef enum logic [1:0] {
        OP_IDLE = 2'b00,
        OP_POP  = 2'b01,
        OP_PUSH = 2'b10,
        OP_BOTH = 2'b11
    } q_op_e;

    function automatic int unsigned ptr_bits(input int unsigned depth);
        return (depth > 1) ? $clog2(depth) : 1;
    endfunction
endpackage

// File: rtl/rxsf_ptr_ctrl.sv
`timescale 1ns/1ps
module rxsf_ptr_ctrl
    import rxsf_pkg::*;
#(
    parameter int unsigned DEPTH = 32,
    localparam int unsigned PTR_W = ptr_bits(DEPTH),
    localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic             push_req,
    input  logic             pop_req,
    output logic [PTR_W-1:0] wr_ptr,
    output logic [PTR_W-1:0] rd_ptr,
    output logic [CNT_W-1:0] fill_cnt,
    output logic             is_empty,
    output logic             is_full,
    output logic             push_ok,
    output logic             pop_ok,
    output logic             drop
);
    logic [PTR_W-1:0] wr_nxt, rd_nxt;
    q_op_e            op;

    assign is_empty = (fill_cnt == '0);
    assign is_full  = (fill_cnt == CNT_W'(DEPTH));
    assign pop_ok   = pop_req && !is_empty;
    assign push_ok  = push_req && (!is_full || pop_ok);
    assign drop     = push_req && !push_ok;
    assign op       = q_op_e'({push_ok, pop_ok});

    generate
        if ((1 << PTR_W) == DEPTH) begin : g_pow2_wrap
            assign wr_nxt = wr_ptr + 1'b1;
            assign rd_nxt = rd_ptr + 1'b1;
        end else begin : g_cmp_wrap
            assign wr_nxt = (wr_ptr == PTR_W'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
            assign rd_nxt = (rd_ptr == PTR_W'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
        end
    endgenerate

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            wr_ptr   <= '0;
            rd_ptr   <= '0;
            fill_cnt <= '0;
        end else begin
            if (push_ok) wr_ptr <= wr_nxt;
            if (pop_ok)  rd_ptr <= rd_nxt;
            case (op)
                OP_PUSH: fill_cnt <= fill_cnt + 1'b1;
                OP_POP:  fill_cnt <= fill_cnt - 1'b1;
                default: fill_cnt <= fill_cnt;
            endcase
        end
    end
endmodule

// File: rtl/rxsf_store.sv
`timescale 1ns/1ps
module rxsf_store
    import rxsf_pkg::*;
#(
    parameter int unsigned DEPTH = 32,
    localparam int unsigned PTR_W = ptr_bits(DEPTH)
) (
    input  logic             clk_i,
    input  logic             we,
    input  logic [PTR_W-1:0] waddr,
    input  rx_entry_t        wentry,
    input  logic [PTR_W-1:0] raddr,
    output rx_entry_t        rentry
);
    rx_entry_t mem [DEPTH];

    always_ff @(posedge clk_i) begin
        if (we) mem[waddr] <= wentry;
    end

    assign rentry = mem[raddr];
endmodule

// File: rtl/rxsf_status.sv
`timescale 1ns/1ps
module rxsf_status
    import rxsf_pkg::*;
(
    input  logic                 clk_i,
    input  logic                 rst_i,
    input  logic                 drop,
    input  logic                 stat_rd,
    input  logic                 pop_ok,
    input  logic [RX_DATA_W-1:0] pop_data,
    output logic                 overrun_q,
    output logic [RX_DATA_W-1:0] last_q
);
    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            overrun_q <= 1'b0;
            last_q    <= '0;
        end else begin
            // a new drop takes priority over a clearing status read
            if (drop)         overrun_q <= 1'b1;
            else if (stat_rd) overrun_q <= 1'b0;
            if (pop_ok)       last_q    <= pop_data;
        end
    end
endmodule

// File: rtl/rx_status_fifo.sv
`timescale 1ns/1ps
module rx_status_fifo
    import rxsf_pkg::*;
#(
    parameter int unsigned DEPTH = 32
) (
    input  logic                 clk_i,
    input  logic                 rst_i,
    input  logic                 wr_valid_i,
    input  logic [RX_DATA_W-1:0] wr_data_i,
    input  logic                 wr_perr_i,
    input  logic                 rd_pop_i,
    input  logic                 rd_stat_i,
    output logic [RX_DATA_W-1:0] rd_data_o,
    output logic                 st_ready_o,
    output logic                 st_overrun_o,
    output logic                 st_perr_o
);
    localparam int unsigned PTR_W = ptr_bits(DEPTH);
    localparam int unsigned CNT_W = $clog2(DEPTH + 1);

    logic [PTR_W-1:0]     wr_ptr, rd_ptr;
    logic [CNT_W-1:0]     fill_cnt;
    logic                 is_empty, is_full, push_ok, pop_ok, drop;
    rx_entry_t            in_entry, head_entry;
    logic [RX_DATA_W-1:0] last_q;

    assign in_entry = '{perr: wr_perr_i, data: wr_data_i};

    rxsf_ptr_ctrl #(.DEPTH(DEPTH)) ptr_i (
        .clk_i    (clk_i),
        .rst_i    (rst_i),
        .push_req (wr_valid_i),
        .pop_req  (rd_pop_i),
        .wr_ptr   (wr_ptr),
        .rd_ptr   (rd_ptr),
        .fill_cnt (fill_cnt),
        .is_empty (is_empty),
        .is_full  (is_full),
        .push_ok  (push_ok),
        .pop_ok   (pop_ok),
        .drop     (drop)
    );

    rxsf_store #(.DEPTH(DEPTH)) store_i (
        .clk_i  (clk_i),
        .we     (push_ok),
        .waddr  (wr_ptr),
        .wentry (in_entry),
        .raddr  (rd_ptr),
        .rentry (head_entry)
    );

    rxsf_status status_i (
        .clk_i     (clk_i),
        .rst_i     (rst_i),
        .drop      (drop),
        .stat_rd   (rd_stat_i),
        .pop_ok    (pop_ok),
        .pop_data  (head_entry.data),
        .overrun_q (st_overrun_o),
        .last_q    (last_q)
    );

    assign st_ready_o = !is_empty;
    assign rd_data_o  = is_empty ? last_q : head_entry.data;
    assign st_perr_o  = !is_empty && head_entry.perr;
endmodule

// File: rtl/rxsf_checker.sv
`timescale 1ns/1ps
module rxsf_checker #(
    parameter int unsigned DEPTH = 32,
    parameter int unsigned CNT_W = 6
) (
    input logic             clk_i,
    input logic             rst_i,
    input logic             wr_valid_i,
    input logic             rd_pop_i,
    input logic             rd_stat_i,
    input logic [7:0]       rd_data_o,
    input logic             st_ready_o,
    input logic             st_overrun_o,
    input logic             st_perr_o,
    input logic [CNT_W-1:0] fill_cnt,
    input logic             is_full
);
    // R1: ready can only rise after a write
    a_r1_ready_needs_write: assert property (@(posedge clk_i) disable iff (rst_i)
        $rose(st_ready_o) |-> $past(wr_valid_i));

    // R2: a write while full without a pop raises overrun
    a_r2_overrun_on_full: assert property (@(posedge clk_i) disable iff (rst_i)
        (is_full && wr_valid_i && !rd_pop_i) |=> st_overrun_o);

    // R3: a dropped write leaves count and head byte unchanged
    a_r3_store_intact: assert property (@(posedge clk_i) disable iff (rst_i)
        (is_full && wr_valid_i && !rd_pop_i) |=> ($stable(fill_cnt) && $stable(rd_data_o)));

    // R4: no parity tag while empty
    a_r4_perr_needs_data: assert property (@(posedge clk_i) disable iff (rst_i)
        !st_ready_o |-> !st_perr_o);

    // R6: status read without a new drop clears overrun
    a_r6_stat_clears: assert property (@(posedge clk_i) disable iff (rst_i)
        (rd_stat_i && !(wr_valid_i && is_full && !rd_pop_i)) |=> !st_overrun_o);

    // R6: overrun only rises with a dropped write
    a_r6_overrun_cause: assert property (@(posedge clk_i) disable iff (rst_i)
        $rose(st_overrun_o) |-> $past(wr_valid_i && is_full));

    // R7: write plus pop while full keeps the queue full
    a_r7_full_both: assert property (@(posedge clk_i) disable iff (rst_i)
        (is_full && wr_valid_i && rd_pop_i) |=> (fill_cnt == CNT_W'(DEPTH)));

    // R8: pop on empty with no write changes nothing
    a_r8_empty_pop: assert property (@(posedge clk_i) disable iff (rst_i)
        (!st_ready_o && rd_pop_i && !wr_valid_i) |=> ($stable(rd_data_o) && !st_ready_o));

    // R9: count never exceeds capacity
    a_r9_cap_bound: assert property (@(posedge clk_i) disable iff (rst_i)
        fill_cnt <= CNT_W'(DEPTH));
endmodule

bind rx_status_fifo rxsf_checker #(.DEPTH(DEPTH), .CNT_W(CNT_W)) chk_i (
    .clk_i        (clk_i),
    .rst_i        (rst_i),
    .wr_valid_i   (wr_valid_i),
    .rd_pop_i     (rd_pop_i),
    .rd_stat_i    (rd_stat_i),
    .rd_data_o    (rd_data_o),
    .st_ready_o   (st_ready_o),
    .st_overrun_o (st_overrun_o),
    .st_perr_o    (st_perr_o),
    .fill_cnt     (fill_cnt),
    .is_full      (is_full)
);

// File: tb/rx_status_fifo_tb_top.sv
`timescale 1ns/1ps
module rx_status_fifo_tb_top;
    localparam int DEPTH = 32;

    logic       clk = 1'b0;
    logic       rst_i = 1'b1;
    logic       wr_valid_i = 1'b0;
    logic [7:0] wr_data_i = 8'h00;
    logic       wr_perr_i = 1'b0;
    logic       rd_pop_i = 1'b0;
    logic       rd_stat_i = 1'b0;
    logic [7:0] rd_data_o;
    logic       st_ready_o, st_overrun_o, st_perr_o;

    int n_checks = 0;
    int n_fails  = 0;
    int cycles   = 0;

    typedef struct { logic [7:0] d; logic p; } item_t;
    item_t      sb_q[$];
    logic       m_ovr  = 1'b0;
    logic [7:0] m_last = 8'h00;

    always #2.5 clk = ~clk;

    rx_status_fifo #(.DEPTH(DEPTH)) dut_i (
        .clk_i(clk), .rst_i(rst_i), .wr_valid_i(wr_valid_i), .wr_data_i(wr_data_i),
        .wr_perr_i(wr_perr_i), .rd_pop_i(rd_pop_i), .rd_stat_i(rd_stat_i),
        .rd_data_o(rd_data_o), .st_ready_o(st_ready_o),
        .st_overrun_o(st_overrun_o), .st_perr_o(st_perr_o)
    );

    task automatic chk(input logic ok, input string tag, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    // compare all outputs to the scoreboard model
    task automatic check_outputs(input string sc);
        logic       e_rdy  = (sb_q.size() > 0);
        logic [7:0] e_data = e_rdy ? sb_q[0].d : m_last;
        logic       e_perr = e_rdy ? sb_q[0].p : 1'b0;
        chk(st_ready_o == e_rdy, {sc, " R1 ready"}, st_ready_o, e_rdy);
        chk(st_overrun_o == m_ovr, {sc, " R2/R6 overrun"}, st_overrun_o, m_ovr);
        chk(st_perr_o == e_perr, {sc, " R4 perr"}, st_perr_o, e_perr);
        chk(rd_data_o == e_data, {sc, " R4/R8 data"}, rd_data_o, e_data);
    endtask

    // driver: one cycle of stimulus, model update, then output check
    task automatic step(input logic wv, input logic [7:0] wd, input logic wp,
                        input logic pop, input logic stat, input string sc);
        logic acc_pop, acc_wr;
        @(negedge clk);
        wr_valid_i = wv; wr_data_i = wd; wr_perr_i = wp;
        rd_pop_i = pop; rd_stat_i = stat;
        acc_pop = pop && (sb_q.size() > 0);
        acc_wr  = wv && ((sb_q.size() < DEPTH) || acc_pop);
        if (acc_pop) begin
            // monitor: popped byte must match the head of the scoreboard
            chk(rd_data_o == sb_q[0].d, {sc, " R9 pop order"}, rd_data_o, sb_q[0].d);
            m_last = sb_q[0].d;
            void'(sb_q.pop_front());
        end
        if (acc_wr) sb_q.push_back('{d: wd, p: wp});
        if (wv && !acc_wr) m_ovr = 1'b1;
        else if (stat)     m_ovr = 1'b0;
        @(posedge clk); #1;
        wr_valid_i = 1'b0; rd_pop_i = 1'b0; rd_stat_i = 1'b0;
        check_outputs(sc);
    endtask

    initial begin : watchdog
        while (cycles < 100000) begin
            @(posedge clk);
            cycles++;
        end
        n_checks++; n_fails++;
        $display("FAIL watchdog actual=%0d expected=<100000 cycles", cycles);
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    initial begin : main
        logic [15:0] lfsr = 16'hACE1;
        repeat (3) @(posedge clk);
        #1;
        // R5: flags clear during reset
        chk(st_ready_o == 0, "R5 ready in reset", st_ready_o, 0);
        chk(st_overrun_o == 0, "R5 overrun in reset", st_overrun_o, 0);
        chk(st_perr_o == 0, "R5 perr in reset", st_perr_o, 0);
        chk(rd_data_o == 8'h00, "R5 data in reset", rd_data_o, 0);
        @(negedge clk); rst_i = 1'b0;
        @(posedge clk); #1;
        check_outputs("R5 after reset");

        // short burst with mixed parity tags
        step(1, 8'h41, 0, 0, 0, "R4 push a");
        step(1, 8'h42, 1, 0, 0, "R4 push b");
        step(1, 8'h43, 0, 0, 0, "R4 push c");
        step(0, 8'h00, 0, 1, 0, "R4 pop a");
        chk(st_perr_o == 1, "R4 perr follows head", st_perr_o, 1);
        step(0, 8'h00, 0, 1, 0, "R4 pop b");
        step(0, 8'h00, 0, 1, 0, "R4 pop c");

        // R8: pops on an empty queue
        step(0, 8'h00, 0, 1, 0, "R8 empty pop");
        step(0, 8'h00, 0, 1, 1, "R8 empty pop2");
        chk(rd_data_o == 8'h43, "R8 last byte held", rd_data_o, 8'h43);

        // R9: fill to capacity
        for (int i = 0; i < DEPTH; i++)
            step(1, 8'(8'h80 + i), i[0], 0, 0, "R9 fill");
        chk(st_overrun_o == 0, "R9 full without overrun", st_overrun_o, 0);

        // R2/R3: write on full is dropped
        step(1, 8'hEE, 1, 0, 0, "R2 drop");
        chk(st_overrun_o == 1, "R2 overrun set", st_overrun_o, 1);
        chk(rd_data_o == 8'h80, "R3 head intact", rd_data_o, 8'h80);
        step(0, 8'h00, 0, 0, 0, "R6 sticky");
        step(0, 8'h00, 0, 0, 1, "R6 clear");
        chk(st_overrun_o == 0, "R6 cleared by status read", st_overrun_o, 0);

        // R6: new drop in the same cycle as a status read wins
        step(1, 8'hEF, 0, 0, 1, "R6 set wins");
        chk(st_overrun_o == 1, "R6 set beats clear", st_overrun_o, 1);
        step(0, 8'h00, 0, 0, 1, "R6 clear2");

        // R7: write and pop together while full
        step(1, 8'hA5, 1, 1, 0, "R7 both");
        chk(st_overrun_o == 0, "R7 no overrun", st_overrun_o, 0);

        // R3: drain all, order and tags checked by the monitor
        for (int i = 0; i < DEPTH; i++)
            step(0, 8'h00, 0, 1, 0, "R3 drain");
        chk(st_ready_o == 0, "R1 empty after drain", st_ready_o, 0);
        chk(rd_data_o == 8'hA5, "R8 last after drain", rd_data_o, 8'hA5);

        // R9: long mixed traffic across many wraps
        for (int i = 0; i < 3000; i++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            step(lfsr[0] | lfsr[1], lfsr[9:2], lfsr[10], lfsr[11] & lfsr[12],
                 lfsr[13] & lfsr[14] & lfsr[15], "R9 mixed");
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end
endmodule